// File: doc/BRIEF.md
# Multi-Mode Pin Interrupt Controller

This block turns eight external interrupt pins into pending requests for a processor core. A configuration strobe loads a small mode word. The word sets how the pins are read and whether they are sampled as levels or as rising edges. In the independent layout, each pin is a separate request. In the encoded layout, all eight pins carry one vector number. In the split layout, the three low pins are separate requests and the five high pins carry a small vector number.

Pins first pass through a two-stage synchronizer. Requests are then latched. The block presents one request at a time to the core: a valid flag, a flag that says whether the request is an encoded vector, and the pin index or vector number. The core clears a serviced request with an acknowledge strobe.

Top module: `pin_irq_top`

## Requirements
- R1: After reset no request is pending and `reqValid` is 0. The mode is the independent layout with level sensing.
- R2: `cfgData[1:0]` selects the layout: 0 is independent, 1 is encoded, 2 is split, and 3 behaves like 0. `cfgData[2]`=1 selects edge sensing. In the independent layout with edge sensing, a rising pin latches a request for that pin, and the request is reported with `reqIsVector`=0 and `reqId` equal to the pin index.
- R3: With edge sensing, a pin that stays high creates no new request after it is acknowledged. A fresh request needs the pin to go low and then high again.
- R4: With level sensing, a request is latched whenever its pin is high. An acknowledge has no effect while the pin stays high. A latched request stays pending after the pin falls, until it is acknowledged.
- R5: Among pending pin requests, the lowest index is reported first. Pin requests are reported before an encoded vector.
- R6: In the encoded layout, `pins[7:0]` is the vector number. Codes with `pins[7:4]`=0 mean no interrupt. A valid code is reported with `reqIsVector`=1 and `reqId` equal to the code.
- R7: With edge sensing, an encoded vector is latched only when the field changes to a valid code. A code that is held after its acknowledge creates no new request.
- R8: In the split layout, pins 0 to 2 are independent requests. `pins[7:3]` is a vector field, where 0 means no interrupt and 1 to 31 are reported as the vector number.
- R9: An acknowledge with `ackIsVector`=1 clears the vector request only if `ackId` equals the pending vector number. An acknowledge with `ackIsVector`=0 clears the pin request selected by `ackId`.
- R10: A configuration write clears every pending request by the following cycle.
- R11: A pin rising between clock edges is reported after the third rising edge that follows, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pins | input | 8 | External interrupt pins, asynchronous |
| cfgWrite | input | 1 | Strobe that loads `cfgData` |
| cfgData | input | 3 | Bits 1:0 select the layout, bit 2 selects edge sensing |
| ackStrobe | input | 1 | Acknowledge strobe from the core |
| ackIsVector | input | 1 | The acknowledge targets the encoded vector |
| ackId | input | 8 | Pin index or vector number being acknowledged |
| reqValid | output | 1 | A request is pending |
| reqIsVector | output | 1 | The reported request is an encoded vector |
| reqId | output | 8 | Pin index or vector number of the reported request |

## Verification
The independent layout is swept with every non-empty combination of pins. Draining each combination one acknowledge at a time separates correct lowest-first priority from a wrong order, and shows whether every pin has its own latch. The encoded layout is swept over all 256 codes with edge sensing, which finds the boundary between idle codes and valid codes. The split layout is swept over all 32 field values crossed with all 8 combinations of the low pins, which shows that pin requests are reported before the vector and that the pins are split at the correct position. Directed sequences cover a pin held high after its acknowledge, acknowledges under level sensing, a mismatched vector acknowledge, clearing by a configuration write, and the exact cycle of synchronizer latency.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int PIN_W = 8;
  localparam int ID_W  = 8;

  typedef enum logic [1:0] {
    MODE_DED = 2'd0,
    MODE_EXP = 2'd1,
    MODE_MIX = 2'd2,
    MODE_RSV = 2'd3
  } pinMode_e;

  typedef struct packed {
    pinMode_e mode;
    logic     edgeMode;
  } irqCfg_t;

  typedef struct packed {
    logic             clearAll;
    logic [PIN_W-1:0] ackIndep;
    logic             ackVec;
    logic [ID_W-1:0]  ackVecId;
  } ctrlStrobe_t;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [2:0]        cfgData,
  input  logic              ackStrobe,
  input  logic              ackIsVector,
  input  logic [ID_W-1:0]   ackId,
  output irqCfg_t           cfgNow,
  output ctrlStrobe_t       strobes
);
  localparam int SEL_W = $clog2(PIN_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgNow.mode     <= MODE_DED;
      cfgNow.edgeMode <= 1'b0;
    end else if (cfgWrite) begin
      cfgNow.mode     <= pinMode_e'(cfgData[1:0]);
      cfgNow.edgeMode <= cfgData[2];
    end
  end

  logic indepHit;
  assign indepHit = ackStrobe && !ackIsVector && (ackId < ID_W'(PIN_W));

  always_comb begin
    strobes          = '0;
    strobes.clearAll = cfgWrite;
    if (indepHit) strobes.ackIndep[ackId[SEL_W-1:0]] = 1'b1;
    strobes.ackVec   = ackStrobe && ackIsVector;
    strobes.ackVecId = ackId;
  end
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int MIX_INDEP = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIN_W-1:0]  syncPins,
  input  irqCfg_t           cfgNow,
  input  ctrlStrobe_t       strobes,
  output logic              reqValid,
  output logic              reqIsVector,
  output logic [ID_W-1:0]   reqId,
  output logic [PIN_W-1:0]  pendIndep
);
  localparam logic [PIN_W-1:0] MIX_MASK = PIN_W'((1 << MIX_INDEP) - 1);
  localparam int NIB = PIN_W / 2;

  logic [PIN_W-1:0] prevPins;
  logic [PIN_W-1:0] indepMask;
  logic [PIN_W-1:0] setIndep;
  logic [ID_W-1:0]  curField, prevField;
  logic             codeValid, setVec;
  logic             vecPend;
  logic [ID_W-1:0]  vecId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPins <= '0;
    else       prevPins <= syncPins;
  end

  always_comb begin
    unique case (cfgNow.mode)
      MODE_EXP: indepMask = '0;
      MODE_MIX: indepMask = MIX_MASK;
      default:  indepMask = '1;
    endcase
  end

  always_comb begin
    if (cfgNow.mode == MODE_EXP) begin
      curField  = ID_W'(syncPins);
      prevField = ID_W'(prevPins);
      codeValid = |syncPins[PIN_W-1:NIB];
    end else if (cfgNow.mode == MODE_MIX) begin
      curField  = ID_W'(syncPins >> MIX_INDEP);
      prevField = ID_W'(prevPins >> MIX_INDEP);
      codeValid = |(syncPins >> MIX_INDEP);
    end else begin
      curField  = '0;
      prevField = '0;
      codeValid = 1'b0;
    end
  end

  assign setIndep = cfgNow.edgeMode ? (syncPins & ~prevPins & indepMask)
                                    : (syncPins & indepMask);
  assign setVec   = codeValid && (!cfgNow.edgeMode || (curField != prevField));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pendIndep <= '0;
    else if (strobes.clearAll) pendIndep <= '0;
    else                       pendIndep <= (pendIndep & ~strobes.ackIndep) | setIndep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecPend <= 1'b0;
      vecId   <= '0;
    end else if (strobes.clearAll) begin
      vecPend <= 1'b0;
    end else if (setVec) begin
      vecPend <= 1'b1;
      vecId   <= curField;
    end else if (strobes.ackVec && strobes.ackVecId == vecId) begin
      vecPend <= 1'b0;
    end
  end

  logic            pinFound;
  logic [ID_W-1:0] pinPick;
  always_comb begin
    pinFound = 1'b0;
    pinPick  = '0;
    for (int i = PIN_W - 1; i >= 0; i--) begin
      if (pendIndep[i]) begin
        pinFound = 1'b1;
        pinPick  = ID_W'(i);
      end
    end
  end

  assign reqValid    = pinFound || vecPend;
  assign reqIsVector = !pinFound && vecPend;
  assign reqId       = pinFound ? pinPick : (vecPend ? vecId : '0);
endmodule

// File: rtl/pin_irq_top.sv
module pin_irq_top
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIX_INDEP   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       pins,
  input  logic             cfgWrite,
  input  logic [2:0]       cfgData,
  input  logic             ackStrobe,
  input  logic             ackIsVector,
  input  logic [7:0]       ackId,
  output logic             reqValid,
  output logic             reqIsVector,
  output logic [7:0]       reqId
);
  logic [PIN_W-1:0] syncPins;
  logic [PIN_W-1:0] pendIndep;
  irqCfg_t          cfgNow;
  ctrlStrobe_t      strobes;

  pin_irq_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pins), .syncOut(syncPins)
  );

  pin_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .ackStrobe(ackStrobe), .ackIsVector(ackIsVector), .ackId(ackId),
    .cfgNow(cfgNow), .strobes(strobes)
  );

  pin_irq_datapath #(.MIX_INDEP(MIX_INDEP)) u_dp (
    .clk(clk), .rstN(rstN), .syncPins(syncPins), .cfgNow(cfgNow),
    .strobes(strobes), .reqValid(reqValid), .reqIsVector(reqIsVector),
    .reqId(reqId), .pendIndep(pendIndep)
  );
endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrite,
  input logic [1:0] modeNow,
  input logic [7:0] pendIndep,
  input logic       reqValid,
  input logic       reqIsVector,
  input logic [7:0] reqId
);
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !reqValid); // R10

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsVector) |-> ((pendIndep & ((8'd1 << reqId[2:0]) - 8'd1)) == 8'd0)); // R5

  AST_PIN_BEFORE_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (pendIndep != 8'd0) |-> (reqValid && !reqIsVector)); // R5

  AST_EXP_ONLY_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'd1 && reqValid && !$past(cfgWrite)) |-> (reqIsVector && reqId[7:4] != 4'd0)); // R6

  AST_MIX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'd2 && reqValid && !$past(cfgWrite)) |-> (reqIsVector ? (reqId < 8'd32 && reqId != 8'd0) : (reqId < 8'd3))); // R8

  AST_DED_NO_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 2'd0 && !$past(cfgWrite)) |-> !reqIsVector); // R2
endmodule

bind pin_irq_top pin_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .modeNow(cfgNow.mode),
  .pendIndep(pendIndep), .reqValid(reqValid), .reqIsVector(reqIsVector),
  .reqId(reqId)
);

// File: tb/pin_irq_top_bench.sv
module pin_irq_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pins = '0;
  logic       cfgWrite = 1'b0;
  logic [2:0] cfgData = '0;
  logic       ackStrobe = 1'b0;
  logic       ackIsVector = 1'b0;
  logic [7:0] ackId = '0;
  logic       reqValid, reqIsVector;
  logic [7:0] reqId;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pin_irq_top u_pin_irq_top (
    .clk(clk), .rstN(rstN), .pins(pins), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .ackStrobe(ackStrobe), .ackIsVector(ackIsVector), .ackId(ackId),
    .reqValid(reqValid), .reqIsVector(reqIsVector), .reqId(reqId)
  );

  task automatic expectReq(string tag, logic expV, logic expIsV, logic [7:0] expId);
    total++;
    if (reqValid !== expV || (expV && (reqIsVector !== expIsV || reqId !== expId))) begin
      bad++;
      $display("FAIL %s: valid=%0b isVec=%0b id=%0d expected valid=%0b isVec=%0b id=%0d",
               tag, reqValid, reqIsVector, reqId, expV, expIsV, expId);
    end
  endtask

  task automatic setPins(logic [7:0] v);
    @(negedge clk) pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic setCfg(logic [1:0] mode, logic edgeSel);
    @(negedge clk) begin cfgWrite = 1'b1; cfgData = {edgeSel, mode}; end
    @(negedge clk) cfgWrite = 1'b0;
  endtask

  task automatic ack(logic isVec, logic [7:0] id);
    @(negedge clk) begin ackStrobe = 1'b1; ackIsVector = isVec; ackId = id; end
    @(negedge clk) ackStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectReq("R1 reset idle", 1'b0, 1'b0, 8'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expectReq("R1 after release", 1'b0, 1'b0, 8'd0);

    // R2 / R3 per pin, independent layout with edge sensing
    setCfg(2'd0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      setPins(8'd1 << i);
      expectReq("R2 pin edge", 1'b1, 1'b0, 8'(i));
      ack(1'b0, 8'(i));
      expectReq("R3 held high no new", 1'b0, 1'b0, 8'd0);
      setPins(8'd0);
      expectReq("R3 low no request", 1'b0, 1'b0, 8'd0);
      setPins(8'd1 << i);
      expectReq("R3 re-rise", 1'b1, 1'b0, 8'(i));
      ack(1'b0, 8'(i));
      setPins(8'd0);
    end

    // R5 priority sweep over every non-empty combination
    for (int m = 1; m < 256; m++) begin
      setPins(8'(m));
      for (int b = 0; b < 8; b++) begin
        if (m[b]) begin
          expectReq("R5 lowest first", 1'b1, 1'b0, 8'(b));
          ack(1'b0, 8'(b));
        end
      end
      expectReq("R5 drained", 1'b0, 1'b0, 8'd0);
      setPins(8'd0);
    end

    // layout code 3 acts as independent
    setCfg(2'd3, 1'b1);
    setPins(8'h40);
    expectReq("R2 code 3 independent", 1'b1, 1'b0, 8'd6);
    ack(1'b0, 8'd6);
    setPins(8'd0);

    // R4 level sensing
    setCfg(2'd0, 1'b0);
    setPins(8'h08);
    expectReq("R4 level pending", 1'b1, 1'b0, 8'd3);
    ack(1'b0, 8'd3);
    expectReq("R4 ack ignored while high", 1'b1, 1'b0, 8'd3);
    setPins(8'h00);
    expectReq("R4 latched after fall", 1'b1, 1'b0, 8'd3);
    ack(1'b0, 8'd3);
    expectReq("R4 cleared after fall", 1'b0, 1'b0, 8'd0);
    setPins(8'h0C);
    expectReq("R4 level priority", 1'b1, 1'b0, 8'd2);
    setPins(8'h00);
    ack(1'b0, 8'd2);
    ack(1'b0, 8'd3);
    expectReq("R4 drained", 1'b0, 1'b0, 8'd0);

    // R6 / R7 encoded layout sweep with edge sensing
    setCfg(2'd1, 1'b1);
    for (int c = 0; c < 256; c++) begin
      setPins(8'd0);
      setPins(8'(c));
      if (c >= 16) begin
        expectReq("R6 valid code", 1'b1, 1'b1, 8'(c));
        ack(1'b1, 8'(c));
        expectReq("R7 held code no new", 1'b0, 1'b0, 8'd0);
      end else begin
        expectReq("R6 idle code", 1'b0, 1'b0, 8'd0);
      end
    end
    setPins(8'h20);
    setPins(8'h21);
    expectReq("R7 change to new code", 1'b1, 1'b1, 8'h21);
    ack(1'b1, 8'h21);

    // R9 acknowledge matching
    setPins(8'd0);
    setPins(8'h20);
    ack(1'b1, 8'h21);
    expectReq("R9 mismatched vector ack", 1'b1, 1'b1, 8'h20);
    ack(1'b0, 8'd0);
    expectReq("R9 pin ack leaves vector", 1'b1, 1'b1, 8'h20);
    ack(1'b1, 8'h20);
    expectReq("R9 matching ack", 1'b0, 1'b0, 8'd0);

    // encoded layout with level sensing
    setCfg(2'd1, 1'b0);
    setPins(8'h35);
    expectReq("R6 level code", 1'b1, 1'b1, 8'h35);
    ack(1'b1, 8'h35);
    expectReq("R4 level code ack ignored", 1'b1, 1'b1, 8'h35);
    setPins(8'h00);
    ack(1'b1, 8'h35);
    expectReq("R4 level code cleared", 1'b0, 1'b0, 8'd0);

    // R8 split layout sweep
    setCfg(2'd2, 1'b1);
    for (int f = 0; f < 32; f++) begin
      for (int m = 0; m < 8; m++) begin
        setPins(8'd0);
        setPins({5'(f), 3'(m)});
        for (int b = 0; b < 3; b++) begin
          if (m[b]) begin
            expectReq("R8 split pin before vector", 1'b1, 1'b0, 8'(b));
            ack(1'b0, 8'(b));
          end
        end
        if (f != 0) begin
          expectReq("R8 split vector", 1'b1, 1'b1, 8'(f));
          ack(1'b1, 8'(f));
        end
        expectReq("R8 split drained", 1'b0, 1'b0, 8'd0);
      end
    end
    setPins(8'd0);

    // R10 configuration write clears
    setCfg(2'd0, 1'b1);
    setPins(8'h20);
    expectReq("R10 pending before write", 1'b1, 1'b0, 8'd5);
    setCfg(2'd0, 1'b1);
    expectReq("R10 cleared by write", 1'b0, 1'b0, 8'd0);
    setPins(8'd0);

    // R11 synchronizer latency
    @(negedge clk) pins = 8'h02;
    repeat (2) @(negedge clk);
    expectReq("R11 not yet visible", 1'b0, 1'b0, 8'd0);
    @(negedge clk);
    expectReq("R11 visible on third edge", 1'b1, 1'b0, 8'd1);
    ack(1'b0, 8'd1);
    setPins(8'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule